// File: doc/BRIEF.md
# Staged Trigger Matcher with Aligned Trigger Position

This block watches a stream of 16-channel logic samples and decides when a programmable trigger condition has been met. The condition is split into up to four ordered stages. Each stage holds two independent per-channel condition sets (copy A and copy B) and a combine code that joins them. Each channel of a copy can demand a high level, a low level, a rising edge, a falling edge, any transition, or nothing at all. Edge terms compare the current sample with the previous accepted sample. A stage may also demand a run of consecutive matching samples before it counts. The trigger fires when the last active stage is satisfied. The block then raises a one-cycle hit pulse and holds a latched flag until it is armed again.

Stage contents are loaded through a simple write port. The global trigger word, the requested pre-trigger depth, the memory depth and the streaming flag are plain inputs that are captured when `arm` is pulsed. At the same moment the block computes the pre-trigger sample count it reports to the capture controller. This count has a floor of 64 samples, is capped at a percentage of memory depth, and is rounded down to a 64-sample boundary.

Samples arrive on a valid/ready interface. The block never applies back-pressure. `s_ready` rises in the first cycle after reset and then stays high. A sample is accepted in every cycle where `s_valid` and `s_ready` are both high. Every accepted sample becomes the previous sample for edge detection, whether or not the block is armed.

Top module: `stage_trigger_unit`

## Requirements
- R1: After reset, `trig_hit`, `trig_latched` and `trig_pos` are 0. Every stage defaults to both masks 0xFFFF, values 0, edges 0, combine code 2 and count 0, so a default stage matches any sample.
- R2: A channel with mask 0 and edge 0 matches when the sample bit equals its value bit: value 1 means high and value 0 means low.
- R3: A channel with mask 0 and edge 1 matches a rising edge when its value bit is 1 and a falling edge when its value bit is 0. The edge is judged against the previous accepted sample, and that includes the sample accepted in the arm cycle.
- R4: A channel with mask 1 and edge 1 matches any transition. A channel with mask 1 and edge 0 always matches.
- R5: Bits [7:4] of `glb_word` give the enabled channel count N. Channels with index N or above always match. N=0 enables all channels.
- R6: Each stage's 2-bit combine code joins its two copies as follows: 0 means A AND B, 1 means A only, 2 means A OR B, 3 means B only.
- R7: A stage with count field C advances only after max(C,1) consecutive matching samples. A non-matching sample restarts the run.
- R8: Bits [3:0] of `glb_word` give the number of active stages; values above 4 are treated as 4. Stages are satisfied in order from stage 0, and the trigger fires on the last active stage. With 0 stages, the first accepted sample after arm fires.
- R9: `trig_hit` is a one-cycle pulse in the cycle after the firing sample is accepted. `trig_latched` rises at the same time and stays high until the next arm, and no further pulse occurs before that arm.
- R10: `arm` clears both the hit pulse and the latched flag and restarts at stage 0. The sample accepted in the arm cycle is not matched; it only updates the previous sample.
- R11: At arm, `trig_pos` is computed and held until the next arm. The computation takes max(`pos_req`,64), limits it to `mem_depth`*90/100 (or `mem_depth`*10/100 when `stream_mode` is 1), and clears the result's low 6 bits.
- R12: Once high after reset, `s_ready` stays high, so samples are never held off.
- R13: Configuration writes use `cfg_addr` = {stage, field[2:0]} with these field codes: 0 mask A, 1 mask B, 2 value A, 3 value B, 4 edge A, 5 edge B, 6 combine code, 7 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stage configuration write strobe |
| cfg_addr | input | 5 | {stage, field} write address |
| cfg_wdata | input | 32 | Write data |
| arm | input | 1 | Restart matching and capture global inputs |
| glb_word | input | 8 | [7:4] enabled channel count, [3:0] active stages |
| pos_req | input | 32 | Requested pre-trigger samples |
| mem_depth | input | 32 | Sample memory depth |
| stream_mode | input | 1 | Selects 10% cap instead of 90% |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always high after reset |
| s_data | input | 16 | Sample, one bit per channel |
| trig_hit | output | 1 | One-cycle trigger pulse |
| trig_latched | output | 1 | Trigger seen since last arm |
| trig_pos | output | 32 | Aligned pre-trigger sample count |

## Verification
An arm pulse and a sample that would complete the trigger can land in the same cycle. The bench provokes this by configuring a stage for channel 0 high and arming with a sample that already has channel 0 high. That must yield no pulse. The next matching sample must fire as sample one of the new run, and its edge terms must see the arm-cycle sample as their predecessor. A scoreboard queue holds the expected firing sample index, and any pulse that arrives with no entry in the queue counts as a failure.

// File: rtl/stu_pkg.sv
package stu_pkg;
  typedef enum logic [2:0] {
    FLD_MASK_A  = 3'd0,
    FLD_MASK_B  = 3'd1,
    FLD_VAL_A   = 3'd2,
    FLD_VAL_B   = 3'd3,
    FLD_EDGE_A  = 3'd4,
    FLD_EDGE_B  = 3'd5,
    FLD_COMBINE = 3'd6,
    FLD_COUNT   = 3'd7
  } field_e;

  typedef enum logic [1:0] {
    CMB_AND    = 2'd0,
    CMB_A_ONLY = 2'd1,
    CMB_OR     = 2'd2,
    CMB_B_ONLY = 2'd3
  } combine_e;

  localparam int CNT_W        = 32;
  localparam int POS_W        = 32;
  localparam int POS_ALIGN    = 64;
  localparam int PCT_BUFFERED = 90;
  localparam int PCT_STREAM   = 10;
endpackage

// File: rtl/stu_stage_cmp.sv
module stu_stage_cmp #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0]      sample,
  input  logic [NCH-1:0]      prev,
  input  logic                have_prev,
  input  logic [NCH-1:0]      chan_en,
  input  logic [1:0][NCH-1:0] mask,
  input  logic [1:0][NCH-1:0] value,
  input  logic [1:0][NCH-1:0] edge_sel,
  input  logic [1:0]          combine,
  output logic                hit
);
  import stu_pkg::*;

  logic [1:0] copy_ok;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      logic [NCH-1:0] term;
      for (int i = 0; i < NCH; i++) begin
        logic rise, fall;
        rise = have_prev & ~prev[i] & sample[i];
        fall = have_prev & prev[i] & ~sample[i];
        if (!chan_en[i])            term[i] = 1'b1;
        else if (mask[c][i])        term[i] = edge_sel[c][i] ? (rise | fall) : 1'b1;
        else if (edge_sel[c][i])    term[i] = value[c][i] ? rise : fall;
        else                        term[i] = (sample[i] == value[c][i]);
      end
      copy_ok[c] = &term;
    end
  end

  always_comb begin
    case (combine_e'(combine))
      CMB_AND:    hit = copy_ok[0] & copy_ok[1];
      CMB_A_ONLY: hit = copy_ok[0];
      CMB_OR:     hit = copy_ok[0] | copy_ok[1];
      default:    hit = copy_ok[1];
    endcase
  end
endmodule

// File: rtl/stu_pos_calc.sv
module stu_pos_calc #(
  parameter int W     = stu_pkg::POS_W,
  parameter int ALIGN = stu_pkg::POS_ALIGN
) (
  input  logic [W-1:0] req,
  input  logic [W-1:0] depth,
  input  logic         stream,
  output logic [W-1:0] pos
);
  import stu_pkg::*;

  localparam int       PW       = W + 8;
  localparam logic [W-1:0] LOW_MASK = W'(ALIGN - 1);

  logic [PW-1:0] prod, cap;
  logic [W-1:0]  floored, clamped;

  always_comb begin
    prod    = {8'd0, depth} * (stream ? PW'(PCT_STREAM) : PW'(PCT_BUFFERED));
    cap     = prod / PW'(100);
    floored = (req < W'(ALIGN)) ? W'(ALIGN) : req;
    clamped = ({8'd0, floored} > cap) ? cap[W-1:0] : floored;
    pos     = clamped & ~LOW_MASK;
  end
endmodule

// File: rtl/stu_sequencer.sv
module stu_sequencer #(
  parameter int NSTAGES = 4,
  parameter int CW      = stu_pkg::CNT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         arm,
  input  logic                         take,
  input  logic [NSTAGES-1:0]           stage_hit,
  input  logic [3:0]                   nst_in,
  input  logic [NSTAGES-1:0][CW-1:0]   need_cnt,
  output logic                         trig_hit,
  output logic                         trig_latched
);
  localparam int IW = (NSTAGES > 1) ? $clog2(NSTAGES) : 1;

  logic          armed_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] run_q;
  logic [3:0]    nst_q;

  logic          cur_hit, run_done, is_last;
  logic [CW-1:0] need;

  always_comb begin
    cur_hit  = stage_hit[idx_q];
    need     = (need_cnt[idx_q] == '0) ? CW'(1) : need_cnt[idx_q];
    run_done = ({1'b0, run_q} + (CW+1)'(1)) >= {1'b0, need};
    is_last  = (4'(idx_q) + 4'd1) == nst_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      idx_q        <= '0;
      run_q        <= '0;
      nst_q        <= '0;
      trig_hit     <= 1'b0;
      trig_latched <= 1'b0;
    end else begin
      trig_hit <= 1'b0;
      if (arm) begin
        armed_q      <= 1'b1;
        idx_q        <= '0;
        run_q        <= '0;
        nst_q        <= nst_in;
        trig_latched <= 1'b0;
      end else if (take && armed_q) begin
        if (nst_q == 4'd0 || (cur_hit && run_done && is_last)) begin
          armed_q      <= 1'b0;
          trig_latched <= 1'b1;
          trig_hit     <= 1'b1;
          run_q        <= '0;
        end else if (cur_hit && run_done) begin
          run_q <= '0;
          idx_q <= idx_q + IW'(1);
        end else if (cur_hit) begin
          run_q <= run_q + CW'(1);
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/stage_trigger_unit.sv
module stage_trigger_unit #(
  parameter int NCH     = 16,
  parameter int NSTAGES = 4,
  parameter int SW      = (NSTAGES > 1) ? $clog2(NSTAGES) : 1,
  parameter int AW      = SW + 3,
  parameter int DW      = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           arm,
  input  logic [7:0]     glb_word,
  input  logic [31:0]    pos_req,
  input  logic [31:0]    mem_depth,
  input  logic           stream_mode,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [NCH-1:0] s_data,
  output logic           trig_hit,
  output logic           trig_latched,
  output logic [31:0]    trig_pos
);
  import stu_pkg::*;

  logic [NSTAGES-1:0][1:0][NCH-1:0] mask_q, val_q, edge_q;
  logic [NSTAGES-1:0][1:0]          comb_q;
  logic [NSTAGES-1:0][CNT_W-1:0]    cnt_q;

  logic [SW-1:0] w_stage;
  field_e        w_field;
  assign w_stage = cfg_addr[AW-1:3];
  assign w_field = field_e'(cfg_addr[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTAGES; s++) begin
        mask_q[s] <= '1;
        val_q[s]  <= '0;
        edge_q[s] <= '0;
        comb_q[s] <= 2'(CMB_OR);
        cnt_q[s]  <= '0;
      end
    end else if (cfg_we && (int'(w_stage) < NSTAGES)) begin
      case (w_field)
        FLD_MASK_A:  mask_q[w_stage][0] <= cfg_wdata[NCH-1:0];
        FLD_MASK_B:  mask_q[w_stage][1] <= cfg_wdata[NCH-1:0];
        FLD_VAL_A:   val_q[w_stage][0]  <= cfg_wdata[NCH-1:0];
        FLD_VAL_B:   val_q[w_stage][1]  <= cfg_wdata[NCH-1:0];
        FLD_EDGE_A:  edge_q[w_stage][0] <= cfg_wdata[NCH-1:0];
        FLD_EDGE_B:  edge_q[w_stage][1] <= cfg_wdata[NCH-1:0];
        FLD_COMBINE: comb_q[w_stage]    <= cfg_wdata[1:0];
        default:     cnt_q[w_stage]     <= cfg_wdata[CNT_W-1:0];
      endcase
    end
  end

  logic           take, rdy_q, have_prev_q;
  logic [NCH-1:0] prev_q, chan_en;
  logic [3:0]     chcnt_q, nst_clamped;
  logic [31:0]    pos_next;

  assign s_ready = rdy_q;
  assign take    = s_valid & rdy_q;
  assign nst_clamped = (int'(glb_word[3:0]) > NSTAGES) ? 4'(NSTAGES) : glb_word[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q       <= 1'b0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      chcnt_q     <= '0;
      trig_pos    <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (take) begin
        prev_q      <= s_data;
        have_prev_q <= 1'b1;
      end
      if (arm) begin
        chcnt_q  <= glb_word[7:4];
        trig_pos <= pos_next;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      chan_en[i] = (chcnt_q == 4'd0) || (int'(chcnt_q) > i);
  end

  logic [NSTAGES-1:0] stage_hit;

  for (genvar g = 0; g < NSTAGES; g++) begin : g_stage
    stu_stage_cmp #(.NCH(NCH)) u_cmp (
      .sample    (s_data),
      .prev      (prev_q),
      .have_prev (have_prev_q),
      .chan_en   (chan_en),
      .mask      (mask_q[g]),
      .value     (val_q[g]),
      .edge_sel  (edge_q[g]),
      .combine   (comb_q[g]),
      .hit       (stage_hit[g])
    );
  end

  stu_pos_calc #(.W(32), .ALIGN(POS_ALIGN)) u_pos (
    .req    (pos_req),
    .depth  (mem_depth),
    .stream (stream_mode),
    .pos    (pos_next)
  );

  stu_sequencer #(.NSTAGES(NSTAGES), .CW(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .take         (take),
    .stage_hit    (stage_hit),
    .nst_in       (nst_clamped),
    .need_cnt     (cnt_q),
    .trig_hit     (trig_hit),
    .trig_latched (trig_latched)
  );
endmodule

// File: rtl/stu_checker.sv
module stu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        arm,
  input logic        s_valid,
  input logic        s_ready,
  input logic        trig_hit,
  input logic        trig_latched,
  input logic [31:0] trig_pos
);
  // R9: a pulse lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> !trig_hit);
  // R9: pulse and latch rise together
  a_r9_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> trig_latched);
  // R9: latch holds until arm
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_latched && !arm) |=> trig_latched);
  // R9: a pulse follows an accepted sample
  a_r9_hit_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> $past(s_valid && s_ready && !arm));
  // R10: arm clears both flags
  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!trig_hit && !trig_latched));
  // R11: position always on a 64-sample boundary
  a_r11_pos_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pos[5:0] == 6'd0);
  // R12: ready never drops
  a_r12_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);
endmodule

bind stage_trigger_unit stu_checker u_stu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm          (arm),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .trig_hit     (trig_hit),
  .trig_latched (trig_latched),
  .trig_pos     (trig_pos)
);

// File: tb/tb_stage_trigger_unit.sv
module tb_stage_trigger_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic [7:0]  glb_word = '0;
  logic [31:0] pos_req = '0, mem_depth = '0;
  logic        stream_mode = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        trig_hit, trig_latched;
  logic [31:0] trig_pos;

  always #5 clk = ~clk;

  stage_trigger_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .glb_word(glb_word), .pos_req(pos_req),
    .mem_depth(mem_depth), .stream_mode(stream_mode), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .trig_hit(trig_hit),
    .trig_latched(trig_latched), .trig_pos(trig_pos)
  );

  int n_checks = 0, n_fail = 0, nsent = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && trig_hit) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected trigger pulse", nsent, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(nsent == e, t, nsent, e);
      end
    end
  end

  function automatic longint exp_pos(longint req, longint dep, bit str);
    longint p, cap;
    p   = (req < 64) ? 64 : req;
    cap = (dep * (str ? 10 : 90)) / 100;
    if (p > cap) p = cap;
    return p - (p % 64);
  endfunction

  task automatic wr(int st, int fld, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'((st << 3) | fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R13 field codes: 0 maskA 1 maskB 2 valA 3 valB 4 edgeA 5 edgeB 6 combine 7 count
  task automatic set_stage(int st, logic [15:0] ma, logic [15:0] va, logic [15:0] ea,
                           logic [1:0] lc, logic [31:0] cnt);
    wr(st, 0, {16'd0, ma}); wr(st, 2, {16'd0, va}); wr(st, 4, {16'd0, ea});
    wr(st, 1, 32'h0000_FFFF); wr(st, 3, 0); wr(st, 5, 0);
    wr(st, 6, {30'd0, lc}); wr(st, 7, cnt);
  endtask

  task automatic arm_t(logic [15:0] init, logic [7:0] glb, logic [31:0] req,
                       logic [31:0] dep, bit str);
    @(negedge clk);
    arm = 1'b1; s_valid = 1'b1; s_data = init;
    glb_word = glb; pos_req = req; mem_depth = dep; stream_mode = str;
    @(posedge clk);
    nsent = 0;
    @(negedge clk);
    arm = 1'b0; s_valid = 1'b0;
    check(trig_hit == 0 && trig_latched == 0, "R10 arm clears, arm-cycle sample not matched",
          {trig_hit, trig_latched}, 0);
    check(trig_pos == 32'(exp_pos(req, dep, str)), "R11 trigger position", trig_pos,
          exp_pos(req, dep, str));
    check(s_ready == 1, "R12 ready high", s_ready, 1);
  endtask

  task automatic send(logic [15:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(posedge clk);
    nsent++;
  endtask

  task automatic expect_hit(int idx, string tag);
    exp_q.push_back(idx);
    tag_q.push_back(tag);
  endtask

  task automatic close_scn(string tag);
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " expected pulse missing"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(trig_hit == 0 && trig_latched == 0 && trig_pos == 0, "R1 reset state",
          {trig_hit, trig_latched, trig_pos}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1, "R12 ready after reset", s_ready, 1);

    // R1 default stage matches anything
    arm_t(16'h0, 8'h01, 10, 1000, 0);
    expect_hit(1, "R1 default stage");
    send(16'h1234);
    close_scn("R1");

    // R2 high level on ch3, then R9 latched: no further pulses
    set_stage(0, 16'hFFF7, 16'h0008, 16'h0, 2'd1, 0);
    arm_t(16'h0, 8'h01, 1000, 1000, 0);
    expect_hit(3, "R2 high level");
    send(16'h0); send(16'h0); send(16'h0008);
    send(16'h0008); send(16'h0008);
    close_scn("R2");
    check(trig_latched == 1, "R9 latched holds", trig_latched, 1);

    // R2 low level on ch0
    set_stage(0, 16'hFFFE, 16'h0, 16'h0, 2'd1, 0);
    arm_t(16'h1, 8'h01, 1000, 1000, 1);
    expect_hit(3, "R2 low level");
    send(16'h1); send(16'h1); send(16'h0);
    close_scn("R2b");

    // R3 rising on ch5, predecessor is arm-cycle sample
    set_stage(0, 16'hFFDF, 16'h0020, 16'h0020, 2'd1, 0);
    arm_t(16'h0020, 8'h01, 300, 1000, 0);
    expect_hit(3, "R3 rising edge");
    send(16'h0020); send(16'h0); send(16'h0020);
    close_scn("R3");

    // R3 falling on ch5
    set_stage(0, 16'hFFDF, 16'h0, 16'h0020, 2'd1, 0);
    arm_t(16'h0, 8'h01, 5000, 100000, 1);
    expect_hit(3, "R3 falling edge");
    send(16'h0020); send(16'h0020); send(16'h0);
    close_scn("R3b");

    // R4 any transition on ch7
    set_stage(0, 16'hFFFF, 16'h0, 16'h0080, 2'd1, 0);
    arm_t(16'h0080, 8'h01, 0, 50, 0);
    expect_hit(3, "R4 any transition");
    send(16'h0080); send(16'h0080); send(16'h0);
    close_scn("R4");

    // R5 ch8 beyond enabled count 4 -> don't care
    set_stage(0, 16'hFEFF, 16'h0100, 16'h0, 2'd1, 0);
    arm_t(16'h0, 8'h41, 64, 1000, 0);
    expect_hit(1, "R5 disabled channel ignored");
    send(16'h0);
    close_scn("R5");

    // R6 AND of copies: A ch0 high, B ch1 high
    set_stage(0, 16'hFFFE, 16'h0001, 16'h0, 2'd0, 0);
    wr(0, 1, 32'h0000_FFFD); wr(0, 3, 32'h0000_0002);
    arm_t(16'h0, 8'h01, 64, 1000, 0);
    expect_hit(3, "R6 combine AND");
    send(16'h1); send(16'h2); send(16'h3);
    close_scn("R6");
    wr(0, 6, 2);
    arm_t(16'h0, 8'h01, 64, 1000, 0);
    expect_hit(2, "R6 combine OR");
    send(16'h0); send(16'h2);
    close_scn("R6b");
    wr(0, 6, 3);
    arm_t(16'h0, 8'h01, 64, 1000, 0);
    expect_hit(2, "R6 combine B only");
    send(16'h1); send(16'h2);
    close_scn("R6c");

    // R7 count 3 with a broken run
    set_stage(0, 16'hFFFE, 16'h0001, 16'h0, 2'd1, 3);
    arm_t(16'h0, 8'h01, 64, 1000, 0);
    expect_hit(6, "R7 consecutive count");
    send(16'h1); send(16'h1); send(16'h0); send(16'h1); send(16'h1); send(16'h1);
    close_scn("R7");

    // R8 two stages in order
    set_stage(0, 16'hFFFE, 16'h0001, 16'h0, 2'd1, 0);
    set_stage(1, 16'hFFFD, 16'h0002, 16'h0, 2'd1, 0);
    arm_t(16'h0, 8'h02, 64, 1000, 0);
    expect_hit(4, "R8 stage order");
    send(16'h2); send(16'h1); send(16'h1); send(16'h2);
    close_scn("R8");

    // R8 zero stages fires at once
    arm_t(16'h0, 8'h00, 64, 1000, 0);
    expect_hit(1, "R8 zero stages");
    send(16'h0);
    close_scn("R8b");

    // R10 arm collides with a matching sample
    set_stage(1, 16'hFFFF, 16'h0, 16'h0, 2'd2, 0);
    arm_t(16'h0001, 8'h01, 64, 1000, 0);
    expect_hit(1, "R10 arm-cycle sample skipped");
    send(16'h0001);
    close_scn("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule